// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Byte Lanes

This block is a clocked static memory model with a 2-bit burst address counter and byte-masked writes. On each rising clock edge it may take in a fresh address from one of two address strobes, step through a four-word group in linear or interleaved order, or hold its current address. Each edge then carries out one access at the resulting address. The access is a write if the write inputs say so, and a read otherwise. Read data comes out after one register (flow-through) or after two registers (pipelined). The data bus is split into an input port, an output port and a drive-enable port. The drive-enable is gated without a clock by the output enable input.

Two strobes are provided. The processor strobe only counts when the master chip enable is active. The controller strobe always counts, whatever the chip enables. A load with any chip enable inactive deselects the device until a later load succeeds. The depth is set by `ADDR_W`. The default of 1024 words keeps elaboration small, and setting `ADDR_W` to 19 gives the full 512K-word array.

Top module: `burst_sram`

## Requirements
- R1: On an edge where the controller strobe is low, or where the processor strobe is low with `sel0_n` low, and all three enables are active (`sel0_n`=0, `sel_hi`=1, `sel_lo_n`=0), `addr_i` is loaded and the access of that same edge uses it.
- R2: With `sel0_n` high, a low processor strobe is ignored. The edge behaves as if no strobe were asserted, so a pending step still advances the burst.
- R3: A load by either strobe with any enable inactive deselects the device. Later step or hold edges perform no access, and `doe_o` stays 0 until a load with all enables active.
- R4: With no effective strobe and `step_n` low, an active device advances the burst count by one. With `step_n` high it repeats the access at the same address.
- R5: With `order_ilv`=0, address bits [1:0] are (base + count) mod 4. For example, base 1 gives 1, 2, 3, 0. The upper address bits never change during a burst.
- R6: With `order_ilv`=1, address bits [1:0] are base XOR count. For example, base 1 gives 1, 0, 3, 2.
- R7: With `wr_all_n` low, both bytes are written from `din_i`, which is sampled on the same edge as the address it applies to.
- R8: With `wr_all_n` high and `byte_wr_en_n` low, lane i (bits 8i+7..8i) is written when `byte_stb_n[i]` is low. If no lane strobe is low, or if `byte_wr_en_n` is high, the edge is a read and memory is unchanged.
- R9: With `flow_thru_n`=0, read data and `doe_o` appear in the cycle after the access edge. With `flow_thru_n`=1, they appear one cycle later.
- R10: `doe_o` is 1 only when `out_en_n` is low and the output stage holds read data. A write edge or a deselected edge leaves it 0, and `out_en_n` takes effect without a clock edge.
- R11: With `sleep_i` high, the edge performs no load, no step, no write and no read.
- R12: After reset (`rst_n` low, synchronous), the device is deselected and `doe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Write data |
| dout_o | output | DATA_W | Read data |
| doe_o | output | 1 | Data bus drive enable |
| sel0_n | input | 1 | Master chip enable, active low |
| sel_hi | input | 1 | Secondary chip enable, active high |
| sel_lo_n | input | 1 | Secondary chip enable, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| byte_wr_en_n | input | 1 | Byte write enable, active low |
| byte_stb_n | input | DATA_W/8 | Per-lane write strobes, active low |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| flow_thru_n | input | 1 | 0 flow-through, 1 pipelined |
| sleep_i | input | 1 | Blocks new cycles |

## Verification
The embedded properties check three things on every clock. They check that the upper address bits stay fixed between loads. They check that a sleep edge leaves the burst state alone and that a global write sets every lane enable. They also check that, in flow-through mode, a write or dead edge is never followed by a driven bus.

Other behaviour needs the bench's directed scenarios. These are the actual data values across linear and interleaved bursts, byte-lane merging, the strobe gating rules and deselect persistence. They also cover the extra cycle of pipelined latency and the unclocked effect of the output enable, since each depends on memory contents or on sequences of several edges.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;
   // low two address bits for a given burst base and count
   function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
      return ilv ? (base ^ cnt) : (base + cnt);
   endfunction
endpackage

// File: rtl/burst_sram_addr.sv
`timescale 1ns/1ps
module burst_sram_addr #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              sel0_n,
   input  logic              sel_hi,
   input  logic              sel_lo_n,
   input  logic              cpu_stb_n,
   input  logic              ctl_stb_n,
   input  logic              step_n,
   input  logic              order_ilv,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              op_live
);
   import burst_sram_pkg::*;

   localparam int HI_W = ADDR_W - 2;

   logic [ADDR_W-1:0] base_q, base_d;
   logic [1:0]        cnt_q, cnt_d;
   logic              act_q, act_d;
   logic              load_c, step_c, en_ok;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("burst_sram_addr: ADDR_W must be at least 3");
      end
   endgenerate

   always_comb begin
      en_ok  = !sel0_n && sel_hi && !sel_lo_n;
      load_c = !sleep_i && (!ctl_stb_n || (!cpu_stb_n && !sel0_n));
      step_c = !sleep_i && !load_c && !step_n && act_q;
      base_d = load_c ? addr_i : base_q;
      cnt_d  = load_c ? 2'd0 : (step_c ? cnt_q + 2'd1 : cnt_q);
      act_d  = load_c ? en_ok : act_q;
      eff_addr = {base_d[ADDR_W-1:2], burst_lo(base_d[1:0], cnt_d, order_ilv)};
      op_live  = rst_n && !sleep_i && act_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
      end else begin
         base_q <= base_d;
         cnt_q  <= cnt_d;
         act_q  <= act_d;
      end
   end

   // R5: upper address bits only move on a load
   a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (load_c || eff_addr[ADDR_W-1:2] == $past(eff_addr[ADDR_W-1:2])));

   // R11: a sleep edge leaves burst count and selection untouched
   a_r11_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> (cnt_q == $past(cnt_q) && act_q == $past(act_q)));

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = base_q[ADDR_W-1:2];
endmodule

// File: rtl/burst_sram_wrdec.sv
`timescale 1ns/1ps
module burst_sram_wrdec #(
   parameter int NLANE = 2
) (
   input  logic             wr_all_n,
   input  logic             byte_wr_en_n,
   input  logic [NLANE-1:0] byte_stb_n,
   output logic [NLANE-1:0] lane_we,
   output logic             is_wr
);
   generate
      if (NLANE < 1) begin : g_bad_lanes
         $error("burst_sram_wrdec: NLANE must be positive");
      end
      for (genvar g = 0; g < NLANE; g++) begin : g_lane
         assign lane_we[g] = !wr_all_n || (!byte_wr_en_n && !byte_stb_n[g]);
      end
   endgenerate

   assign is_wr = |lane_we;
endmodule

// File: rtl/burst_sram_rdpipe.sv
`timescale 1ns/1ps
module burst_sram_rdpipe #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_thru_n,
   input  logic              rd_edge,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] q_data,
   output logic              q_valid
);
   logic [DATA_W-1:0] d1_q, d2_q;
   logic              v1_q, v2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         v2_q <= 1'b0;
      end else begin
         v1_q <= rd_edge;
         v2_q <= v1_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_edge) d1_q <= rd_word;
      d2_q <= d1_q;
   end

   // static mode pick: one register when flow-through, two when pipelined
   assign q_data  = flow_thru_n ? d2_q : d1_q;
   assign q_valid = flow_thru_n ? v2_q : v1_q;
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [DATA_W-1:0]        din_i,
   output logic [DATA_W-1:0]        dout_o,
   output logic                     doe_o,
   input  logic                     sel0_n,
   input  logic                     sel_hi,
   input  logic                     sel_lo_n,
   input  logic                     cpu_stb_n,
   input  logic                     ctl_stb_n,
   input  logic                     step_n,
   input  logic                     wr_all_n,
   input  logic                     byte_wr_en_n,
   input  logic [DATA_W/LANE_W-1:0] byte_stb_n,
   input  logic                     out_en_n,
   input  logic                     order_ilv,
   input  logic                     flow_thru_n,
   input  logic                     sleep_i
);
   localparam int NLANE = DATA_W / LANE_W;
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DATA_W % LANE_W != 0) begin : g_bad_width
         $error("burst_sram: DATA_W must be a multiple of LANE_W");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] eff_addr;
   logic              op_live, is_wr, wr_edge, rd_edge, q_valid;
   logic [NLANE-1:0]  lane_we;
   logic [DATA_W-1:0] rd_word, q_data;

   burst_sram_addr #(.ADDR_W(ADDR_W)) addr_i0 (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .addr_i(addr_i),
      .sel0_n(sel0_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
      .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
      .order_ilv(order_ilv), .eff_addr(eff_addr), .op_live(op_live));

   burst_sram_wrdec #(.NLANE(NLANE)) wrdec_i0 (
      .wr_all_n(wr_all_n), .byte_wr_en_n(byte_wr_en_n),
      .byte_stb_n(byte_stb_n), .lane_we(lane_we), .is_wr(is_wr));

   assign wr_edge = op_live && is_wr;
   assign rd_edge = op_live && !is_wr;
   assign rd_word = mem[eff_addr];

   always_ff @(posedge clk) begin
      if (wr_edge) begin
         for (int l = 0; l < NLANE; l++) begin
            if (lane_we[l]) mem[eff_addr][l*LANE_W +: LANE_W] <= din_i[l*LANE_W +: LANE_W];
         end
      end
   end

   burst_sram_rdpipe #(.DATA_W(DATA_W)) rdpipe_i0 (
      .clk(clk), .rst_n(rst_n), .flow_thru_n(flow_thru_n),
      .rd_edge(rd_edge), .rd_word(rd_word),
      .q_data(q_data), .q_valid(q_valid));

   assign dout_o = q_data;
   assign doe_o  = !out_en_n && q_valid;

   // R7: global write enables every lane regardless of lane strobes
   a_r7_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_all_n |-> (&lane_we));

   // R10: in flow-through mode a write edge never drives the bus next cycle
   a_r10_no_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_thru_n && $past(!flow_thru_n) && $past(wr_edge)) |-> !doe_o);

   // R3: a dead (deselected or sleeping) edge leaves the bus undriven after it
   a_r3_dead_edge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_thru_n && $past(!flow_thru_n) && $past(!op_live)) |-> !doe_o);
endmodule

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;
   localparam int AW = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr_i;
   logic [DW-1:0] din_i, dout_o;
   logic          doe_o;
   logic          sel0_n, sel_hi, sel_lo_n, cpu_stb_n, ctl_stb_n, step_n;
   logic          wr_all_n, byte_wr_en_n, out_en_n, order_ilv, flow_thru_n, sleep_i;
   logic [1:0]    byte_stb_n;

   logic [DW-1:0] shadow [1 << AW];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i), .dout_o(dout_o),
      .doe_o(doe_o), .sel0_n(sel0_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
      .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
      .wr_all_n(wr_all_n), .byte_wr_en_n(byte_wr_en_n), .byte_stb_n(byte_stb_n),
      .out_en_n(out_en_n), .order_ilv(order_ilv), .flow_thru_n(flow_thru_n),
      .sleep_i(sleep_i));

   task automatic idle();
      addr_i = '0; din_i = '0; sel0_n = 0; sel_hi = 1; sel_lo_n = 0;
      cpu_stb_n = 1; ctl_stb_n = 1; step_n = 1; wr_all_n = 1;
      byte_wr_en_n = 1; byte_stb_n = 2'b11; out_en_n = 0; sleep_i = 0;
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_rd(string req, logic [DW-1:0] exp);
      n_chk++;
      if (doe_o !== 1'b1 || dout_o !== exp) begin
         n_bad++;
         $display("FAIL %s: doe=%b data=%h expected doe=1 data=%h", req, doe_o, dout_o, exp);
      end
   endtask

   task automatic chk_quiet(string req);
      n_chk++;
      if (doe_o !== 1'b0) begin
         n_bad++;
         $display("FAIL %s: doe=%b expected 0", req, doe_o);
      end
   endtask

   task automatic load_ctl(logic [AW-1:0] a);
      idle(); addr_i = a; ctl_stb_n = 0;
   endtask

   // R7: global writes, one loaded address plus a 3-step burst
   task automatic t_global_write();
      load_ctl(10'h040); wr_all_n = 0; din_i = 16'hA1B2;
      cyc(); shadow[10'h040] = 16'hA1B2;
      chk_quiet("R10 write edge");
      ctl_stb_n = 1; step_n = 0;
      for (int i = 1; i < 4; i++) begin
         din_i = 16'h1000 * i[15:0] + 16'h0C3;
         cyc(); shadow[10'h040 + i] = din_i;
      end
      idle();
   endtask

   // R5 / R6 / R1 / R4: burst read from base, order picked by ilv
   task automatic t_read_burst(logic [AW-1:0] base, logic ilv, string req);
      order_ilv = ilv;
      load_ctl(base);
      for (int k = 0; k < 4; k++) begin
         logic [1:0] lo;
         lo = ilv ? (base[1:0] ^ k[1:0]) : (base[1:0] + k[1:0]);
         cyc();
         chk_rd(req, shadow[{base[AW-1:2], lo}]);
         ctl_stb_n = 1; step_n = 0;
      end
      idle();
   endtask

   // R4: no step repeats the same address
   task automatic t_hold();
      order_ilv = 0;
      load_ctl(10'h042); cyc(); chk_rd("R4 load", shadow[10'h042]);
      idle(); cyc(); chk_rd("R4 hold1", shadow[10'h042]);
      cyc(); chk_rd("R4 hold2", shadow[10'h042]);
   endtask

   // R8: per-lane writes and the read cases
   task automatic t_byte();
      load_ctl(10'h042); byte_wr_en_n = 0; byte_stb_n = 2'b10; din_i = 16'h5566;
      cyc(); shadow[10'h042][7:0] = 8'h66; chk_quiet("R8 lane0 write");
      load_ctl(10'h042); byte_wr_en_n = 0; byte_stb_n = 2'b01; din_i = 16'h7788;
      cyc(); shadow[10'h042][15:8] = 8'h77; chk_quiet("R8 lane1 write");
      load_ctl(10'h042); byte_wr_en_n = 1; byte_stb_n = 2'b00; din_i = 16'hFFFF;
      cyc(); chk_rd("R8 enable high reads", shadow[10'h042]);
      load_ctl(10'h042); byte_wr_en_n = 0; byte_stb_n = 2'b11; din_i = 16'hEEEE;
      cyc(); chk_rd("R8 no strobe reads", shadow[10'h042]);
      idle();
   endtask

   // R2: processor strobe ignored while master enable is inactive
   task automatic t_cpu_ignored();
      order_ilv = 0;
      load_ctl(10'h040); cyc(); chk_rd("R2 setup", shadow[10'h040]);
      idle(); cpu_stb_n = 0; sel0_n = 1; addr_i = 10'h100; step_n = 0;
      cyc(); chk_rd("R2 step continues", shadow[10'h041]);
      idle();
   endtask

   // R3 / R1: deselect by either strobe, then recovery
   task automatic t_desel();
      idle(); cpu_stb_n = 0; sel_hi = 0; addr_i = 10'h040;
      cyc(); chk_quiet("R3 cpu deselect");
      idle(); step_n = 0;
      cyc(); chk_quiet("R3 step ignored a");
      cyc(); chk_quiet("R3 step ignored b");
      idle(); cpu_stb_n = 0; addr_i = 10'h043;
      cyc(); chk_rd("R1 cpu load", shadow[10'h043]);
      load_ctl(10'h041); sel0_n = 1;
      cyc(); chk_quiet("R3 ctl deselect");
      idle(); step_n = 0;
      cyc(); chk_quiet("R3 stays deselected");
      load_ctl(10'h040);
      cyc(); chk_rd("R1 ctl load", shadow[10'h040]);
      idle();
   endtask

   // R10: output enable without a clock
   task automatic t_oe();
      load_ctl(10'h040); cyc(); idle();
      out_en_n = 1; #1; chk_quiet("R10 oe off");
      out_en_n = 0; #1; chk_rd("R10 oe on", shadow[10'h040]);
      @(negedge clk);
   endtask

   // R11: sleep blocks step, write and read
   task automatic t_sleep();
      order_ilv = 0;
      load_ctl(10'h040); cyc(); chk_rd("R11 setup", shadow[10'h040]);
      idle(); sleep_i = 1; step_n = 0; wr_all_n = 0; din_i = 16'h0000;
      cyc(); chk_quiet("R11 no read");
      idle(); step_n = 0;
      cyc(); chk_rd("R11 no step", shadow[10'h041]);
      load_ctl(10'h040);
      cyc(); chk_rd("R11 no write", shadow[10'h040]);
      idle();
   endtask

   // R9: pipelined latency is one cycle longer
   task automatic t_pipe();
      load_ctl(10'h040); sel_hi = 0; cyc(); idle(); cyc();
      flow_thru_n = 1; cyc(); chk_quiet("R9 pipe flushed");
      order_ilv = 0;
      load_ctl(10'h043); cyc(); chk_quiet("R9 not yet");
      idle(); step_n = 0;
      cyc(); chk_rd("R9 first word", shadow[10'h043]);
      cyc(); chk_rd("R9 second word", shadow[10'h040]);
      idle(); load_ctl(10'h040); sel_hi = 0; cyc(); idle(); cyc(); cyc();
      flow_thru_n = 0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
   end

   initial begin
      idle(); order_ilv = 0; flow_thru_n = 0; rst_n = 0;
      repeat (3) cyc();
      chk_quiet("R12 in reset");
      rst_n = 1; cyc();
      chk_quiet("R12 after reset");
      t_global_write();
      t_read_burst(10'h041, 1'b0, "R5 linear");
      t_read_burst(10'h041, 1'b1, "R6 interleaved");
      t_hold();
      t_byte();
      t_cpu_ignored();
      t_desel();
      t_oe();
      t_sleep();
      t_pipe();
      summary();
   end
endmodule